// File: doc/BRIEF.md
# Segmented Kernel Address Translator

This block maps a 32-bit virtual address to a physical address for the part of the address space that bypasses paging. The top four address bits select one of sixteen segments. A sixteen-bit segment mask in the configuration says which segments are direct-mapped. The physical base of a direct-mapped segment is a 4-bit value taken from one of two nibble-packed base registers. That value replaces the top four address bits, and the low 28 bits pass through unchanged.

The block holds its own configuration. There is a global control word, of which only the two enable bits are kept, plus the segment mask and the two base registers. A single synchronous write port loads them. Each request is presented with a valid strobe. The result is registered and appears one cycle later, together with two flags. One flag marks a direct-mapped translation. The other tells a downstream page unit that it must resolve the address. While translation is switched off, addresses pass straight through.

Top module: `skt_translator`

## Requirements
- R1: After reset all configuration is zero, so translation is off. The registered outputs `out_valid`, `out_pa`, `out_seg` and `out_page` are all zero.
- R2: Translation is on when bit 2 or bit 3 of the global control word (write select 0) is 1. Either bit alone is enough.
- R3: While translation is off, a request returns `out_pa` equal to the request address, with `out_seg`=0 and `out_page`=0.
- R4: The segment number is address bits [31:28]. While translation is on, a segment is direct-mapped when mask bit [n] is 1 (write select 1, bits [15:0]). In that case `out_seg`=1 and `out_page`=0.
- R5: Segments 0..7 take their base from the low base register (select 2). Segments 8..15 take it from the high base register (select 3). The base is the nibble at bits [4*(n mod 8)+3 : 4*(n mod 8)].
- R6: For a direct-mapped segment, `out_pa` is the base nibble in bits [31:28] followed by request address bits [27:0].
- R7: While translation is on and the segment's mask bit is 0, `out_page`=1, `out_seg`=0 and `out_pa`=0.
- R8: A write with `wr_en`=1 stores `wr_data` into the register named by `wr_sel` at the clock edge: 0 is global, 1 is mask, 2 is low base, 3 is high base. A request sampled at that same edge still uses the old contents.
- R9: `out_valid` is `in_valid` delayed by exactly one cycle. The flags and address belong to the request sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Register select: 0 global, 1 mask, 2 low base, 3 high base |
| wr_data | input | 32 | Configuration write data |
| in_valid | input | 1 | Request strobe |
| in_va | input | 32 | Virtual address of the request |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_pa | output | 32 | Physical address (zero when a page lookup is needed) |
| out_seg | output | 1 | Request was direct-mapped through a segment |
| out_page | output | 1 | Request needs the downstream page unit |

## Verification
The bench sweeps all sixteen segments with random base nibbles. A design that swapped the low and high base registers, or indexed the nibble off by one, would return wrong top bits for at least one segment. The mask is driven in alternating patterns, so a design that read the wrong mask bit would raise the page flag for a mapped segment, or the reverse. The enable bits are tried one at a time. A design that tested only one of them would stay transparent with translation requested. A write and a request land on the same edge. A design that forwarded the new value would translate that request with the new base instead of the old one.

// File: rtl/skt_pkg.sv
package skt_pkg;
  localparam int unsigned SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_GLOBAL  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_BASE_LO = 2'd2,
    SEL_BASE_HI = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/skt_cfg_regs.sv
module skt_cfg_regs
  import skt_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned NSEG   = 16,
  parameter int unsigned EN_LO  = 2,
  parameter int unsigned EN_HI  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]    wr_data,
  output logic [1:0]       en_bits,
  output logic [NSEG-1:0]  seg_mask,
  output logic [AW-1:0]    base_lo,
  output logic [AW-1:0]    base_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_bits  <= '0;
      seg_mask <= '0;
      base_lo  <= '0;
      base_hi  <= '0;
    end else if (wr_en) begin
      case (cfg_sel_e'(wr_sel))
        SEL_GLOBAL:  en_bits  <= {wr_data[EN_HI], wr_data[EN_LO]};
        SEL_MASK:    seg_mask <= wr_data[NSEG-1:0];
        SEL_BASE_LO: base_lo  <= wr_data;
        SEL_BASE_HI: base_hi  <= wr_data;
        default: ;
      endcase
    end
  end

  AST_CFG_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_bits == '0 && seg_mask == '0 && base_lo == '0 && base_hi == '0)); // R1
  AST_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_BASE_LO) |=> (base_lo == $past(wr_data))); // R8
  AST_HI_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_BASE_HI) |=> (base_hi == $past(wr_data))); // R8
endmodule

// File: rtl/skt_seg_map.sv
module skt_seg_map #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SEG_W = 4
) (
  input  logic [AW-1:0]          va,
  input  logic [1:0]             en_bits,
  input  logic [(1<<SEG_W)-1:0]  seg_mask,
  input  logic [AW-1:0]          base_lo,
  input  logic [AW-1:0]          base_hi,
  output logic                   mmu_on,
  output logic [AW-1:0]          pa,
  output logic                   seg_hit,
  output logic                   need_page
);
  localparam int unsigned NSEG  = 1 << SEG_W;
  localparam int unsigned HALF  = NSEG / 2;
  localparam int unsigned OFF_W = AW - SEG_W;

  logic [SEG_W-1:0] nib [NSEG];
  logic [SEG_W-1:0] seg;

  for (genvar g = 0; g < NSEG; g++) begin : g_nib
    if (g < HALF) begin : g_lo
      assign nib[g] = base_lo[(g % HALF) * SEG_W +: SEG_W];
    end else begin : g_hi
      assign nib[g] = base_hi[(g % HALF) * SEG_W +: SEG_W];
    end
  end

  assign seg    = va[AW-1 -: SEG_W];
  assign mmu_on = |en_bits;

  always_comb begin
    pa        = va;
    seg_hit   = 1'b0;
    need_page = 1'b0;
    if (mmu_on) begin
      if (seg_mask[seg]) begin
        seg_hit = 1'b1;
        pa      = {nib[seg], va[OFF_W-1:0]};
      end else begin
        need_page = 1'b1;
        pa        = '0;
      end
    end
  end

  always_comb begin
    if (seg_hit) AST_OFFSET_KEPT: assert (pa[OFF_W-1:0] == va[OFF_W-1:0]); // R6
  end
endmodule

// File: rtl/skt_translator.sv
module skt_translator
  import skt_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [AW-1:0]    wr_data,
  input  logic             in_valid,
  input  logic [AW-1:0]    in_va,
  output logic             out_valid,
  output logic [AW-1:0]    out_pa,
  output logic             out_seg,
  output logic             out_page
);
  localparam int unsigned NSEG = 1 << SEG_W;

  logic [1:0]      en_bits;
  logic [NSEG-1:0] seg_mask;
  logic [AW-1:0]   base_lo, base_hi, pa_c;
  logic            mmu_on, hit_c, page_c;

  skt_cfg_regs #(.AW(AW), .NSEG(NSEG)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .en_bits(en_bits), .seg_mask(seg_mask), .base_lo(base_lo), .base_hi(base_hi)
  );

  skt_seg_map #(.AW(AW), .SEG_W(SEG_W)) u_map (
    .va(in_va), .en_bits(en_bits), .seg_mask(seg_mask),
    .base_lo(base_lo), .base_hi(base_hi),
    .mmu_on(mmu_on), .pa(pa_c), .seg_hit(hit_c), .need_page(page_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_seg   <= 1'b0;
      out_page  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pa   <= pa_c;
        out_seg  <= hit_c;
        out_page <= page_c;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid))); // R9
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mmu_on) |=> (out_pa == $past(in_va) && !out_seg && !out_page)); // R3
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_seg && out_page)); // R7
  AST_PAGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_page) |-> (out_pa == '0)); // R7
endmodule

// File: tb/sim_skt_translator.sv
module sim_skt_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_va = '0;
  logic        out_valid;
  logic [31:0] out_pa;
  logic        out_seg, out_page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]  m_en = '0;
  logic [15:0] m_mask = '0;
  logic [31:0] m_lo = '0, m_hi = '0;

  logic [33:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  skt_translator u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .in_valid(in_valid), .in_va(in_va), .out_valid(out_valid),
    .out_pa(out_pa), .out_seg(out_seg), .out_page(out_page)
  );

  function automatic logic [33:0] model(input logic [31:0] va);
    logic [3:0] s;
    logic [3:0] b;
    s = va[31:28];
    if (m_en == 2'b00) return {va, 2'b00};
    if (!m_mask[s]) return {32'h0, 2'b01};
    b = (s < 8) ? m_lo[s[2:0]*4 +: 4] : m_hi[s[2:0]*4 +: 4];
    return {b, va[27:0], 2'b10};
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got pa=%h seg/page=%b expected pa=%h seg/page=%b",
               req, act[33:2], act[1:0], exp[33:2], exp[1:0]);
    end
  endtask

  // One cycle of stimulus: optional write and optional request on the same edge.
  task automatic cycle(input bit w, input logic [1:0] sel, input logic [31:0] d,
                       input bit r, input logic [31:0] va, input string tag);
    @(negedge clk);
    wr_en = w; wr_sel = sel; wr_data = d;
    in_valid = r; in_va = va;
    if (r) begin
      exp_q.push_back(model(va));
      tag_q.push_back(tag);
    end
    if (w) begin
      case (sel)
        2'd0: m_en = {d[3], d[2]};
        2'd1: m_mask = d[15:0];
        2'd2: m_lo = d;
        default: m_hi = d;
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    cycle(1'b1, sel, d, 1'b0, '0, "");
  endtask

  task automatic rq(input logic [31:0] va, input string tag);
    cycle(1'b0, 2'd0, '0, 1'b1, va, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, '0, 1'b0, '0, "");
  endtask

  // Monitor: R9 latency plus scoreboard compare.
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: out_valid=1 with no request pending (expected 0)");
        end else begin
          check(tag_q.pop_front(), {out_pa, out_seg, out_page}, exp_q.pop_front());
        end
      end else if (exp_q.size() != 0) begin
        checks++; errors++;
        $display("FAIL R9: out_valid=0 with %0d requests pending (expected 1)", exp_q.size());
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish (expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset outputs", {out_pa, out_seg, out_page}, 34'h0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: out_valid=%b expected 0", out_valid);
    end
    @(negedge clk); rst = 1'b0;

    // R1/R3: config is cleared, so requests pass through untouched
    rq(32'h1234_5678, "R1 pass after reset");
    rq(32'hF000_0001, "R3 pass-through");
    rq(32'h8ABC_DEF0, "R3 pass-through");
    // mask and bases set but enable still clear: R3
    wr(2'd1, 32'h0000_FFFF);
    wr(2'd2, 32'h7654_3210);
    wr(2'd3, 32'hFEDC_BA98);
    rq(32'h3000_1111, "R3 disabled ignores mask");

    // R2: bit 2 alone
    wr(2'd0, 32'h0000_0004);
    rq(32'h3000_1111, "R2 bit2 enables / R6");
    // R2: bit 3 alone
    wr(2'd0, 32'h0000_0008);
    rq(32'hA123_4567, "R2 bit3 enables / R5 hi");
    // other bits only: stays off
    wr(2'd0, 32'hFFFF_FFF3);
    rq(32'hA123_4567, "R2 other bits do not enable");
    wr(2'd0, 32'h0000_000C);

    // R4/R5/R6/R7: all segments, random bases, alternating masks
    for (int pass = 0; pass < 6; pass++) begin
      logic [31:0] lo, hi, mk;
      lo = $urandom; hi = $urandom;
      mk = (pass == 0) ? 32'h5555 : (pass == 1) ? 32'hAAAA : (pass == 2) ? 32'hFFFF :
           (pass == 3) ? 32'h0000 : {16'h0, 16'($urandom)};
      wr(2'd2, lo); wr(2'd3, hi); wr(2'd1, mk);
      for (int s = 0; s < 16; s++)
        rq({4'(s), 28'($urandom)}, "R4 R5 R6 R7 segment sweep");
    end

    // R8: write and request on the same edge see the old base
    wr(2'd1, 32'h0000_0002);
    wr(2'd2, 32'h0000_00A0);
    cycle(1'b1, 2'd2, 32'h0000_0050, 1'b1, 32'h1000_0ABC, "R8 same-edge old value");
    rq(32'h1000_0ABC, "R8 new value next cycle");
    // R8: disabling on the same edge as a request
    cycle(1'b1, 2'd0, 32'h0, 1'b1, 32'h1FFF_FFFF, "R8 enable change same edge");
    rq(32'h1FFF_FFFF, "R3 after disable");

    // R9: back-to-back then gap
    wr(2'd0, 32'h4);
    rq(32'h0000_0000, "R9 burst");
    rq(32'hFFFF_FFFF, "R9 burst");
    idle(2);
    rq(32'h1234_0000, "R9 after gap");
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule